// File: doc/BRIEF.md
# Polled Receive Stream Unpacker

This block takes frames from a 32-bit streaming slave port, keeps them in an on-chip beat buffer, and lets a CPU that polls, rather than one that takes interrupts, fetch them through three read registers. One register gives the byte count of the frame waiting at the head. One gives a metadata word describing the head beat: its byte strobes, end-of-frame flag and port fields. The third returns the head beat's data and removes that beat. A one-bit control register can switch the receiver input from the normal receive stream to a second, transmit-side stream. This gives a loopback path for testing the CPU software without a network.

Software reads the metadata word first. Zero strobes mean nothing is waiting. Nonzero strobes together with a length of 0 mean the head beat lies inside a frame. Software then pops beats until one carries the end flag, and after that it is aligned to a frame boundary again. The frame byte count is the sum of the strobe bits of all beats in the frame. It is added up while the frame is stored and queued in a small side FIFO, so it can be read before any data is popped.

Top module: `pio_rx_unpacker`

## Requirements
- R1: After reset the metadata and length registers read 0, the control readback bit 0 reads 0, `s_tready` is 1 and `lb_tready` is 0.
- R2: A read at byte offset 0x0 returns the head beat with its bytes reversed (stream lane 0, `tdata[7:0]`, appears in bits 31:24) and removes that beat from the buffer.
- R3: A read at offset 0x4 returns `{dport, sport, 8'h00, last, 3'b000, keep}`. Here dport is `tuser[15:8]` in bits 31:24, sport is `tuser[7:0]` in bits 23:16, the end flag is bit 7 and the strobes are bits 3:0. The read removes nothing.
- R4: A read at offset 0x8 returns the sum of the strobe bits over the whole frame, but only while the head beat is the first beat of a frame whose last beat has already been stored. At all other times it returns 0. The read removes nothing.
- R5: While the buffer is empty, the metadata and length registers read 0, and a read at offset 0x0 returns 0 and leaves the buffer unchanged.
- R6: When the buffer holds `DEPTH` beats the selected source's tready is 0. Every beat offered is then stored once, in arrival order, as space frees.
- R7: Writing 1 to control bit 0 makes the receiver take beats from the `lb_*` stream with `s_tready` held at 0. Writing 0 selects the `s_*` stream with `lb_tready` held at 0. `ctl_rdata[0]` shows the current setting.
- R8: A read at offset 0xC, or at any address with bits 1:0 nonzero, returns 0 and removes nothing.
- R9: With several frames buffered, each frame's length appears in turn, after the last beat of the previous frame has been popped.
- R10: After the first beat of a frame is popped, the length register reads 0 while the metadata still shows nonzero strobes for the following beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | 1 | Receive stream beat valid |
| s_tready | output | 1 | Receive stream ready |
| s_tdata | input | 32 | Receive stream data, lane 0 in bits 7:0 |
| s_tkeep | input | 4 | Receive stream byte strobes |
| s_tlast | input | 1 | Receive stream end of frame |
| s_tuser | input | 16 | Receive stream ports: dport 15:8, sport 7:0 |
| lb_tvalid | input | 1 | Loopback source beat valid |
| lb_tready | output | 1 | Loopback source ready |
| lb_tdata | input | 32 | Loopback source data |
| lb_tkeep | input | 4 | Loopback source byte strobes |
| lb_tlast | input | 1 | Loopback source end of frame |
| lb_tuser | input | 16 | Loopback source ports |
| rx_rd | input | 1 | Register read strobe |
| rx_addr | input | 4 | Register byte offset |
| rx_rdata | output | 32 | Read data, valid from the edge that samples `rx_rd` |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 1 | Loopback enable value to write |
| ctl_rdata | output | 32 | Control register readback, enable in bit 0 |

## Verification
A beat accepted at a rising edge is at the buffer head right after that edge. A frame's length becomes readable after the edge that accepts its last beat. A register read sampled at an edge updates `rx_rdata` and performs any pop at that same edge. A control write changes the source selection and both ready outputs after the edge that samples it. The bench drives every input at a falling edge and samples every output at the next falling edge. Each result is therefore read exactly one edge after the stimulus that causes it, and never while that edge is still settling.

// File: rtl/pio_rx_pkg.sv
package pio_rx_pkg;

   localparam int DATA_W = 32;
   localparam int KEEP_W = DATA_W / 8;
   localparam int PORT_W = 8;
   localparam int USER_W = 2 * PORT_W;
   localparam int CNT_W  = $clog2(KEEP_W + 1);

   // register selectors, taken from byte offset bits 3:2
   localparam logic [1:0] SEL_DATA = 2'd0;
   localparam logic [1:0] SEL_META = 2'd1;
   localparam logic [1:0] SEL_LEN  = 2'd2;

   typedef struct packed {
      logic              first;
      logic              last;
      logic [PORT_W-1:0] dport;
      logic [PORT_W-1:0] sport;
      logic [KEEP_W-1:0] keep;
      logic [DATA_W-1:0] data;
   } beat_t;

   localparam int BEAT_W = $bits(beat_t);

   function automatic logic [CNT_W-1:0] keep_ones(input logic [KEEP_W-1:0] k);
      logic [CNT_W-1:0] n;
      n = '0;
      for (int i = 0; i < KEEP_W; i++) n = n + CNT_W'(k[i]);
      return n;
   endfunction

endpackage

// File: rtl/rx_sync_fifo.sv
module rx_sync_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full,
   output logic [AW:0]      count
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [AW:0]      cnt_q;
   logic             do_push, do_pop;

   assign full    = (cnt_q == (AW+1)'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rp_q];
   assign count   = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= wdata;
   end
endmodule

// File: rtl/rx_frame_len.sv
module rx_frame_len
   import pio_rx_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_ok,
   input  logic [KEEP_W-1:0] keep,
   input  logic              last,
   output logic              first,
   output logic              len_push,
   output logic [LEN_W-1:0]  len_sum
);
   logic [LEN_W-1:0] acc_q;
   logic             mid_q;

   assign first    = !mid_q;
   assign len_sum  = acc_q + LEN_W'(keep_ones(keep));
   assign len_push = beat_ok && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         mid_q <= 1'b0;
      end else if (beat_ok) begin
         acc_q <= last ? '0 : len_sum;
         mid_q <= !last;
      end
   end
endmodule

// File: rtl/rx_reg_port.sv
module rx_reg_port
   import pio_rx_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [3:0]        addr,
   input  beat_t             head,
   input  logic              head_ok,
   input  logic              len_ok,
   input  logic [LEN_W-1:0]  len_head,
   output logic [DATA_W-1:0] rdata,
   output logic              beat_pop,
   output logic              len_pop
);
   logic [DATA_W-1:0] swapped, meta_w, len_w, nxt;
   logic [DATA_W-1:0] rdata_q;
   logic              aligned;
   logic [1:0]        sel;

   for (genvar b = 0; b < KEEP_W; b++) begin : g_swap
      assign swapped[8*b +: 8] = head.data[DATA_W-8-8*b +: 8];
   end

   assign aligned = (addr[1:0] == 2'b00);
   assign sel     = addr[3:2];
   assign meta_w  = head_ok ? {head.dport, head.sport, 8'h00, head.last, 3'b000, head.keep} : '0;
   assign len_w   = (head_ok && head.first && len_ok) ? DATA_W'(len_head) : '0;

   always_comb begin
      nxt = '0;
      if (aligned) begin
         case (sel)
            SEL_DATA: nxt = head_ok ? swapped : '0;
            SEL_META: nxt = meta_w;
            SEL_LEN:  nxt = len_w;
            default:  nxt = '0;
         endcase
      end
   end

   assign beat_pop = rd && aligned && (sel == SEL_DATA) && head_ok;
   assign len_pop  = beat_pop && head.last;
   assign rdata    = rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata_q <= '0;
      else if (rd) rdata_q <= nxt;
   end
endmodule

// File: rtl/pio_rx_unpacker.sv
module pio_rx_unpacker
   import pio_rx_pkg::*;
#(
   parameter int DEPTH        = 8,
   parameter int LEN_W        = 16,
   parameter bit HAS_LOOPBACK = 1'b1,
   localparam int FW = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_tvalid,
   output logic              s_tready,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic [KEEP_W-1:0] s_tkeep,
   input  logic              s_tlast,
   input  logic [USER_W-1:0] s_tuser,
   input  logic              lb_tvalid,
   output logic              lb_tready,
   input  logic [DATA_W-1:0] lb_tdata,
   input  logic [KEEP_W-1:0] lb_tkeep,
   input  logic              lb_tlast,
   input  logic [USER_W-1:0] lb_tuser,
   input  logic              rx_rd,
   input  logic [3:0]        rx_addr,
   output logic [DATA_W-1:0] rx_rdata,
   input  logic              ctl_we,
   input  logic              ctl_wdata,
   output logic [DATA_W-1:0] ctl_rdata
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 2");
   end
   if (LEN_W < CNT_W || LEN_W > DATA_W - 1) begin : g_bad_len
      $error("LEN_W out of range");
   end
   if (KEEP_W * 8 != DATA_W || 2 * PORT_W + 12 + KEEP_W > DATA_W) begin : g_bad_layout
      $error("register layout does not fit the data width");
   end

   logic              loop_en;
   logic              space;
   logic              in_valid, in_last, beat_ok;
   logic [DATA_W-1:0] in_data;
   logic [KEEP_W-1:0] in_keep;
   logic [USER_W-1:0] in_user;
   beat_t             wr_beat, hd_beat;
   logic              beat_empty, beat_full;
   logic [FW-1:0]     beat_cnt;
   logic              is_first, len_push, len_pop, beat_pop;
   logic [LEN_W-1:0]  len_sum, len_head;
   logic              len_empty, len_full;
   logic [FW-1:0]     len_cnt;

   // source selection: loop register and input mux exist only when built in
   if (HAS_LOOPBACK) begin : g_loop
      logic loop_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      loop_q <= 1'b0;
         else if (ctl_we) loop_q <= ctl_wdata;
      end
      assign loop_en  = loop_q;
      assign in_valid = loop_q ? lb_tvalid : s_tvalid;
      assign in_data  = loop_q ? lb_tdata  : s_tdata;
      assign in_keep  = loop_q ? lb_tkeep  : s_tkeep;
      assign in_last  = loop_q ? lb_tlast  : s_tlast;
      assign in_user  = loop_q ? lb_tuser  : s_tuser;
   end else begin : g_noloop
      assign loop_en  = 1'b0;
      assign in_valid = s_tvalid;
      assign in_data  = s_tdata;
      assign in_keep  = s_tkeep;
      assign in_last  = s_tlast;
      assign in_user  = s_tuser;
   end

   assign space     = !beat_full;
   assign s_tready  = space && !loop_en;
   assign lb_tready = space && loop_en;
   assign beat_ok   = in_valid && space;
   assign ctl_rdata = {{(DATA_W-1){1'b0}}, loop_en};

   rx_frame_len #(.LEN_W(LEN_W)) u_len (
      .clk(clk), .rst_n(rst_n), .beat_ok(beat_ok), .keep(in_keep), .last(in_last),
      .first(is_first), .len_push(len_push), .len_sum(len_sum)
   );

   always_comb begin
      wr_beat.first = is_first;
      wr_beat.last  = in_last;
      wr_beat.dport = in_user[USER_W-1 -: PORT_W];
      wr_beat.sport = in_user[PORT_W-1:0];
      wr_beat.keep  = in_keep;
      wr_beat.data  = in_data;
   end

   rx_sync_fifo #(.WIDTH(BEAT_W), .DEPTH(DEPTH)) u_beats (
      .clk(clk), .rst_n(rst_n), .push(beat_ok), .wdata(wr_beat), .pop(beat_pop),
      .head(hd_beat), .empty(beat_empty), .full(beat_full), .count(beat_cnt)
   );

   rx_sync_fifo #(.WIDTH(LEN_W), .DEPTH(DEPTH)) u_lens (
      .clk(clk), .rst_n(rst_n), .push(len_push), .wdata(len_sum), .pop(len_pop),
      .head(len_head), .empty(len_empty), .full(len_full), .count(len_cnt)
   );

   rx_reg_port #(.LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .rd(rx_rd), .addr(rx_addr), .head(hd_beat),
      .head_ok(!beat_empty), .len_ok(!len_empty), .len_head(len_head),
      .rdata(rx_rdata), .beat_pop(beat_pop), .len_pop(len_pop)
   );
endmodule

// File: rtl/pio_rx_unpacker_chk.sv
module pio_rx_unpacker_chk #(
   parameter int DEPTH = 8,
   localparam int FW = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          s_tvalid,
   input logic          s_tready,
   input logic          lb_tvalid,
   input logic          lb_tready,
   input logic          loop_on,
   input logic          rx_rd,
   input logic [3:0]    rx_addr,
   input logic [31:0]   rx_rdata,
   input logic [FW-1:0] fill,
   input logic [FW-1:0] len_fill,
   input logic          len_full
);
   logic took;
   assign took = (s_tvalid && s_tready) || (lb_tvalid && lb_tready);

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FW'(DEPTH));

   assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == FW'(DEPTH)) |-> (!s_tready && !lb_tready));

   assert_one_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_tready && lb_tready));

   assert_loop_blocks_main_R7: assert property (@(posedge clk) disable iff (!rst_n)
      loop_on |-> !s_tready);

   assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && fill == '0) |=> (rx_rdata == 32'h0));

   assert_peek_no_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && rx_addr != 4'h0) |=> (fill >= $past(fill)));

   assert_data_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && rx_addr == 4'h0 && fill != '0 && !took) |=> (fill == $past(fill) - 1'b1));

   assert_len_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (len_fill <= fill) && (fill != FW'(DEPTH) || !len_full || len_fill == fill));
endmodule

bind pio_rx_unpacker pio_rx_unpacker_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
   .lb_tvalid(lb_tvalid), .lb_tready(lb_tready), .loop_on(ctl_rdata[0]),
   .rx_rd(rx_rd), .rx_addr(rx_addr), .rx_rdata(rx_rdata),
   .fill(beat_cnt), .len_fill(len_cnt), .len_full(len_full)
);

// File: tb/sim_pio_rx_unpacker.sv
`timescale 1ns/1ps
module sim_pio_rx_unpacker;
   localparam int DEPTH = 8;
   localparam logic [3:0] A_DATA = 4'h0, A_META = 4'h4, A_LEN = 4'h8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_tvalid = 1'b0, s_tlast = 1'b0, lb_tvalid = 1'b0, lb_tlast = 1'b0;
   logic [31:0] s_tdata = '0, lb_tdata = '0;
   logic [3:0]  s_tkeep = '0, lb_tkeep = '0;
   logic [15:0] s_tuser = '0, lb_tuser = '0;
   logic        rx_rd = 1'b0, ctl_we = 1'b0, ctl_wdata = 1'b0;
   logic [3:0]  rx_addr = '0;
   logic        s_tready, lb_tready;
   logic [31:0] rx_rdata, ctl_rdata;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pio_rx_unpacker #(.DEPTH(DEPTH), .LEN_W(16), .HAS_LOOPBACK(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
      .s_tlast(s_tlast), .s_tuser(s_tuser),
      .lb_tvalid(lb_tvalid), .lb_tready(lb_tready), .lb_tdata(lb_tdata), .lb_tkeep(lb_tkeep),
      .lb_tlast(lb_tlast), .lb_tuser(lb_tuser),
      .rx_rd(rx_rd), .rx_addr(rx_addr), .rx_rdata(rx_rdata),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input bit lb, input logic [31:0] d, input logic [3:0] k,
                       input logic l, input logic [15:0] u);
      @(negedge clk);
      if (lb) begin lb_tvalid = 1'b1; lb_tdata = d; lb_tkeep = k; lb_tlast = l; lb_tuser = u; end
      else    begin s_tvalid  = 1'b1; s_tdata  = d; s_tkeep  = k; s_tlast  = l; s_tuser  = u; end
      while (!(lb ? lb_tready : s_tready)) @(negedge clk);
      @(negedge clk);
      if (lb) lb_tvalid = 1'b0; else s_tvalid = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      @(negedge clk);
      rx_rd = 1'b1; rx_addr = a;
      @(negedge clk);
      rx_rd = 1'b0;
      v = rx_rdata;
   endtask

   task automatic ctl(input logic v);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 s_tready", {31'b0, s_tready}, 32'd1);
      chk("R1 lb_tready", {31'b0, lb_tready}, 32'd0);
      chk("R1 ctl_rdata", ctl_rdata, 32'd0);
      rd(A_META, v); chk("R1 meta", v, 32'd0);
      rd(A_LEN, v);  chk("R1 len", v, 32'd0);
   endtask

   task automatic t_three_beat;
      logic [31:0] v;
      send(1'b0, 32'h11223344, 4'hF, 1'b0, 16'h0201);
      send(1'b0, 32'h55667788, 4'hF, 1'b0, 16'h0201);
      send(1'b0, 32'h000099AA, 4'h3, 1'b1, 16'h0201);
      rd(A_LEN, v);  chk("R4 length 10", v, 32'd10);
      rd(A_META, v); chk("R3 meta first", v, 32'h0201000F);
      rd(A_LEN, v);  chk("R4 length reread", v, 32'd10);
      rd(A_DATA, v); chk("R2 data swap 0", v, 32'h44332211);
      rd(A_LEN, v);  chk("R10 mid length", v, 32'd0);
      rd(A_META, v); chk("R10 mid meta", v, 32'h0201000F);
      rd(A_DATA, v); chk("R2 data swap 1", v, 32'h88776655);
      rd(A_META, v); chk("R3 meta last", v, 32'h02010083);
      rd(A_DATA, v); chk("R2 data swap 2", v, 32'hAA990000);
      rd(A_META, v); chk("R5 empty meta", v, 32'd0);
   endtask

   task automatic t_empty_and_odd_addr;
      logic [31:0] v;
      rd(A_DATA, v); chk("R5 empty data", v, 32'd0);
      rd(A_LEN, v);  chk("R5 empty len", v, 32'd0);
      send(1'b0, 32'hCAFEF00D, 4'hF, 1'b1, 16'h0905);
      rd(4'hC, v);   chk("R8 offset C", v, 32'd0);
      rd(4'h2, v);   chk("R8 misaligned", v, 32'd0);
      rd(A_META, v); chk("R8 nothing removed", v, 32'h0905008F);
      rd(A_DATA, v); chk("R2 single beat", v, 32'h0DF0FECA);
   endtask

   task automatic t_incomplete;
      logic [31:0] v;
      send(1'b0, 32'h01020304, 4'hF, 1'b0, 16'h0706);
      rd(A_LEN, v);  chk("R4 incomplete len", v, 32'd0);
      rd(A_META, v); chk("R4 incomplete meta", v, 32'h0706000F);
      send(1'b0, 32'h00000005, 4'h1, 1'b1, 16'h0706);
      rd(A_LEN, v);  chk("R4 completed len", v, 32'd5);
      rd(A_DATA, v); chk("R2 incomplete d0", v, 32'h04030201);
      rd(A_DATA, v); chk("R2 incomplete d1", v, 32'h05000000);
   endtask

   task automatic t_queue_order;
      logic [31:0] v;
      send(1'b0, 32'h000000EE, 4'h1, 1'b1, 16'h0101);
      send(1'b0, 32'h12345678, 4'hF, 1'b0, 16'h0202);
      send(1'b0, 32'h00ABCDEF, 4'h7, 1'b1, 16'h0202);
      rd(A_LEN, v);  chk("R9 len A", v, 32'd1);
      rd(A_DATA, v); chk("R9 data A", v, 32'hEE000000);
      rd(A_LEN, v);  chk("R9 len B", v, 32'd7);
      rd(A_DATA, v);
      rd(A_DATA, v); chk("R9 data B end", v, 32'hEFCDAB00);
   endtask

   task automatic t_backpressure;
      logic [31:0] v;
      for (int i = 0; i < DEPTH; i++) send(1'b0, 32'hA0 + i, 4'h1, 1'b1, 16'h0000);
      @(negedge clk);
      s_tvalid = 1'b1; s_tdata = 32'hA0 + DEPTH; s_tkeep = 4'h1; s_tlast = 1'b1; s_tuser = '0;
      chk("R6 full ready low", {31'b0, s_tready}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R6 still stalled", {31'b0, s_tready}, 32'd0);
      rd(A_DATA, v); chk("R6 drain 0", v, 32'hA0000000);
      @(negedge clk);
      s_tvalid = 1'b0;
      for (int i = 1; i <= DEPTH; i++) begin
         rd(A_DATA, v); chk("R6 drain order", v, (32'hA0 + i) << 24);
      end
      rd(A_META, v); chk("R6 drained empty", v, 32'd0);
   endtask

   task automatic t_loopback;
      logic [31:0] v;
      ctl(1'b1);
      chk("R7 ctl readback", ctl_rdata, 32'd1);
      chk("R7 main blocked", {31'b0, s_tready}, 32'd0);
      chk("R7 loop ready", {31'b0, lb_tready}, 32'd1);
      @(negedge clk);
      s_tvalid = 1'b1; s_tdata = 32'h99999999; s_tkeep = 4'hF; s_tlast = 1'b1; s_tuser = 16'h3333;
      send(1'b1, 32'hDEADBEEF, 4'hF, 1'b1, 16'h0403);
      rd(A_META, v); chk("R7 loop meta", v, 32'h0403008F);
      rd(A_LEN, v);  chk("R7 loop len", v, 32'd4);
      rd(A_DATA, v); chk("R7 loop data", v, 32'hEFBEADDE);
      rd(A_META, v); chk("R7 main ignored", v, 32'd0);
      @(negedge clk);
      s_tvalid = 1'b0;
      ctl(1'b0);
      chk("R7 ctl cleared", ctl_rdata, 32'd0);
      chk("R7 loop blocked", {31'b0, lb_tready}, 32'd0);
      chk("R7 main ready", {31'b0, s_tready}, 32'd1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_three_beat();
      t_empty_and_odd_addr();
      t_incomplete();
      t_queue_order();
      t_backpressure();
      t_loopback();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule